// File: doc/BRIEF.md
# Predicate Next-Active Element Finder

This block walks a predicate vector one 64-bit word per clock and performs one of two element-selection operations. Every predicate bit stands for one byte lane of a data vector, so for wider elements only the bit at the start of each element counts. The "seek" operation finds the last element that is active in the current predicate D. It then selects the first element after it that is active in the governing predicate G, and it returns a predicate holding only that element, or an empty predicate. The "mark first" operation adds the lowest governing bit to D and leaves every other bit of D as it was.

Both operations also return a condition word that describes the result predicate against the governing one. The word reports whether the first governing element is set, whether any governing element is set, whether the last governing element is clear, and whether any governing bit exists at all. A request is taken on a single-cycle start pulse while the block is idle. The operands are captured at that moment. A one-cycle done pulse marks the point where the result and the condition word are valid. They stay valid until the next request is accepted.

Top module: `pred_next_finder`

## Requirements
- R1: After reset, busy and done are 0, d_out is all zero and flags is zero.
- R2: For seek, esz selects the element size: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8. Only predicate bits whose index is a multiple of 2^esz take part, both in D and in G. All other bits are ignored, and the result never has a bit set outside those positions.
- R3: For seek, d_out holds a single 1 at the lowest qualifying G position that is strictly above the highest qualifying D position. That position may lie in a later word.
- R4: For seek, when D has no qualifying bit set, the search starts at bit 0.
- R5: For seek, d_out is all zero when no qualifying G bit exists at or after the start position. This includes the case where the start lies at or beyond the end of the vector.
- R6: The condition word uses these bits. Bit 31 is set when the result has the lowest governing bit. Bit 1 is set when the result and the governing predicate overlap. Bit 0 is set when the result lacks the highest governing bit. Bit 2 is set when the governing predicate is not empty. All other bits are 0. For seek, the governing predicate is G restricted to the qualifying positions.
- R7: For mark first (op_next = 0), the lowest set bit of the whole G (no element masking) is ORed into D and all other D bits stay unchanged. With an all-zero G, D is returned unchanged.
- R8: For mark first, the condition word is computed over the resulting D and the unmasked G, with the encoding of R6.
- R9: When the governing predicate is empty, flags equals 1.
- R10: done is a one-cycle pulse. It comes NWORDS cycles after the accepting edge for mark first and 3*NWORDS cycles after it for seek. busy is high in between.
- R11: A start pulse while busy is ignored. The running request finishes with its own operands and its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| op_next | input | 1 | 1 = seek next element, 0 = mark first governing bit |
| esz | input | 2 | Element size code (seek only) |
| d_in | input | NWORDS*64 | Current predicate D |
| g_in | input | NWORDS*64 | Governing predicate G |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| d_out | output | NWORDS*64 | Resulting predicate |
| flags | output | 32 | Condition word (bits 31, 2, 1, 0) |

## Verification
The bench builds the block with NWORDS = 4, which gives a 256-bit predicate. This size places the last active D element, the search start and the found G element in different words. It lets the start position fall inside a word, exactly on a word boundary, or past the top of the vector. With four words, the first, last and interior words are all distinct, so the condition-word cases in which the lowest and highest governing bits sit in separate words can be reached for every element size.

// File: rtl/pnx_pkg.sv
package pnx_pkg;
  localparam int WORD_W = 64;
  localparam int BIT_W  = 6;

  typedef logic [WORD_W-1:0] pword_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_LAST, ST_SEEK, ST_WRITE, ST_DONE
  } pnx_state_e;

  typedef struct packed {
    logic neg;
    logic seen;
    logic any;
    logic carry;
  } pnx_flags_t;

  localparam pnx_flags_t FLAGS_INIT = '{neg: 1'b0, seen: 1'b0, any: 1'b0, carry: 1'b1};

  // positions that start an element of size 2^esz bytes
  function automatic pword_t elem_mask(input logic [1:0] esz);
    pword_t m;
    for (int b = 0; b < WORD_W; b++) begin
      m[b] = ((b & ((1 << int'(esz)) - 1)) == 0);
    end
    return m;
  endfunction

  function automatic logic [BIT_W-1:0] low_index(input pword_t v);
    logic [BIT_W-1:0] idx;
    idx = '0;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (v[b]) idx = BIT_W'(b);
    end
    return idx;
  endfunction

  function automatic logic [BIT_W-1:0] high_index(input pword_t v);
    logic [BIT_W-1:0] idx;
    idx = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (v[b]) idx = BIT_W'(b);
    end
    return idx;
  endfunction

  function automatic pword_t lowest_bit(input pword_t v);
    return v & (~v + pword_t'(1));
  endfunction

  // fold one word pair into the running condition state
  function automatic pnx_flags_t flag_step(input pnx_flags_t f, input pword_t d, input pword_t g);
    pnx_flags_t r;
    r = f;
    if (g != '0) begin
      if (!r.seen) begin
        r.neg  = |(d & lowest_bit(g));
        r.seen = 1'b1;
      end
      r.any   = r.any | (|(d & g));
      r.carry = ~d[high_index(g)];
    end
    return r;
  endfunction

  function automatic logic [31:0] flag_word(input pnx_flags_t f);
    return {f.neg, 28'd0, f.seen, f.any, f.carry};
  endfunction
endpackage

// File: rtl/pnx_ctrl.sv
module pnx_ctrl
  import pnx_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_next,
  output pnx_state_e       state_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  pnx_state_e       st_q;
  logic [IDX_W-1:0] cnt_q;
  logic             at_top;

  assign accept_o = start && (st_q == ST_IDLE || st_q == ST_DONE);
  assign at_top   = (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (accept_o) begin
      st_q  <= op_next ? ST_LAST : ST_FIRST;
      cnt_q <= op_next ? LAST_IDX : '0;
    end else begin
      unique case (st_q)
        ST_FIRST: begin
          if (at_top) st_q <= ST_DONE;
          else        cnt_q <= cnt_q + IDX_W'(1);
        end
        ST_LAST: begin
          if (cnt_q == '0) st_q <= ST_SEEK;
          else             cnt_q <= cnt_q - IDX_W'(1);
        end
        ST_SEEK: begin
          if (at_top) begin
            st_q  <= ST_WRITE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + IDX_W'(1);
          end
        end
        ST_WRITE: begin
          if (at_top) st_q <= ST_DONE;
          else        cnt_q <= cnt_q + IDX_W'(1);
        end
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
  assign busy_o  = (st_q == ST_FIRST) || (st_q == ST_LAST) ||
                   (st_q == ST_SEEK)  || (st_q == ST_WRITE);
  assign done_o  = (st_q == ST_DONE);
endmodule

// File: rtl/pnx_word_scan.sv
module pnx_word_scan
  import pnx_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int IDX_W  = 2,
  parameter int POS_W  = 9
) (
  input  pword_t           d_word,
  input  pword_t           g_word,
  input  logic [1:0]       esz,
  input  logic [IDX_W-1:0] cnt,
  input  logic [POS_W-1:0] start_pos,
  output logic             d_hit,
  output logic [BIT_W-1:0] d_hi_bit,
  output logic             g_hit,
  output pword_t           g_low_vec,
  output pword_t           gm_word,
  output logic             c_hit,
  output logic [BIT_W-1:0] c_lo_bit
);
  localparam logic [POS_W-1:0] VEC_BITS = POS_W'(NWORDS * WORD_W);

  pword_t           emask;
  pword_t           md;
  pword_t           win;
  pword_t           cand;
  logic             in_range;
  logic [IDX_W-1:0] s_word;
  logic [BIT_W-1:0] s_bit;

  assign emask    = elem_mask(esz);
  assign md       = d_word & emask;
  assign gm_word  = g_word & emask;
  assign d_hit    = |md;
  assign d_hi_bit = high_index(md);

  assign g_hit     = |g_word;
  assign g_low_vec = lowest_bit(g_word);

  assign in_range = (start_pos < VEC_BITS);
  assign s_word   = start_pos[BIT_W +: IDX_W];
  assign s_bit    = start_pos[BIT_W-1:0];

  always_comb begin
    if (!in_range)          win = '0;
    else if (cnt > s_word)  win = '1;
    else if (cnt == s_word) win = '1 << s_bit;
    else                    win = '0;
  end

  assign cand     = gm_word & win;
  assign c_hit    = |cand;
  assign c_lo_bit = low_index(cand);
endmodule

// File: rtl/pnx_flag_acc.sv
module pnx_flag_acc
  import pnx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step_en,
  input  pword_t     d_word,
  input  pword_t     g_word,
  output pnx_flags_t flags_o
);
  pnx_flags_t f_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       f_q <= '0;
    else if (clear)   f_q <= FLAGS_INIT;
    else if (step_en) f_q <= flag_step(f_q, d_word, g_word);
  end

  assign flags_o = f_q;
endmodule

// File: rtl/pred_next_finder.sv
module pred_next_finder
  import pnx_pkg::*;
#(
  parameter int NWORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     op_next,
  input  logic [1:0]               esz,
  input  logic [NWORDS*WORD_W-1:0] d_in,
  input  logic [NWORDS*WORD_W-1:0] g_in,
  output logic                     busy,
  output logic                     done,
  output logic [NWORDS*WORD_W-1:0] d_out,
  output logic [31:0]              flags
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int LOC_W = IDX_W + BIT_W;
  localparam int POS_W = IDX_W + BIT_W + 1;

  pnx_state_e       st;
  logic [IDX_W-1:0] cnt;
  logic             evt_accept;

  pword_t           d_q [NWORDS];
  pword_t           g_q [NWORDS];
  logic [1:0]       esz_q;
  logic             op_q;
  logic             have_last;
  logic [LOC_W-1:0] last_pos;
  logic             found;
  logic [LOC_W-1:0] hit_pos;

  pword_t           cur_d, cur_g;
  logic [POS_W-1:0] start_pos;
  logic             d_hit, g_hit, c_hit;
  logic [BIT_W-1:0] d_hi_bit, c_lo_bit;
  pword_t           g_low_vec, gm_word;

  // named internal events
  logic   evt_first_set, evt_last_hit, evt_seek_hit;
  pword_t d_first_new, write_word, acc_d, acc_g;
  pnx_flags_t acc_q;

  pnx_ctrl #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_next  (op_next),
    .state_o  (st),
    .cnt_o    (cnt),
    .accept_o (evt_accept),
    .busy_o   (busy),
    .done_o   (done)
  );

  assign cur_d = d_q[cnt];
  assign cur_g = g_q[cnt];

  assign start_pos = have_last ? (POS_W'(last_pos) + (POS_W'(1) << esz_q)) : '0;

  pnx_word_scan #(.NWORDS(NWORDS), .IDX_W(IDX_W), .POS_W(POS_W)) u_scan (
    .d_word    (cur_d),
    .g_word    (cur_g),
    .esz       (esz_q),
    .cnt       (cnt),
    .start_pos (start_pos),
    .d_hit     (d_hit),
    .d_hi_bit  (d_hi_bit),
    .g_hit     (g_hit),
    .g_low_vec (g_low_vec),
    .gm_word   (gm_word),
    .c_hit     (c_hit),
    .c_lo_bit  (c_lo_bit)
  );

  assign evt_first_set = (st == ST_FIRST) && !found && g_hit;
  assign evt_last_hit  = (st == ST_LAST)  && !have_last && d_hit;
  assign evt_seek_hit  = (st == ST_SEEK)  && !found && c_hit;

  assign d_first_new = cur_d | (evt_first_set ? g_low_vec : '0);
  assign write_word  = (found && (hit_pos[BIT_W +: IDX_W] == cnt)) ?
                       (pword_t'(1) << hit_pos[BIT_W-1:0]) : '0;

  assign acc_d = (st == ST_FIRST) ? d_first_new : write_word;
  assign acc_g = (st == ST_FIRST) ? cur_g : gm_word;

  pnx_flag_acc u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (evt_accept),
    .step_en ((st == ST_FIRST) || (st == ST_WRITE)),
    .d_word  (acc_d),
    .g_word  (acc_g),
    .flags_o (acc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORDS; w++) begin
        d_q[w] <= '0;
        g_q[w] <= '0;
      end
      esz_q     <= '0;
      op_q      <= 1'b0;
      have_last <= 1'b0;
      last_pos  <= '0;
      found     <= 1'b0;
      hit_pos   <= '0;
    end else if (evt_accept) begin
      for (int w = 0; w < NWORDS; w++) begin
        d_q[w] <= d_in[w*WORD_W +: WORD_W];
        g_q[w] <= g_in[w*WORD_W +: WORD_W];
      end
      esz_q     <= esz;
      op_q      <= op_next;
      have_last <= 1'b0;
      found     <= 1'b0;
    end else begin
      if (st == ST_FIRST) begin
        d_q[cnt] <= d_first_new;
        if (evt_first_set) found <= 1'b1;
      end
      if (evt_last_hit) begin
        have_last <= 1'b1;
        last_pos  <= {cnt, d_hi_bit};
      end
      if (evt_seek_hit) begin
        found   <= 1'b1;
        hit_pos <= {cnt, c_lo_bit};
      end
      if (st == ST_WRITE) d_q[cnt] <= write_word;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_pack
    assign d_out[w*WORD_W +: WORD_W] = d_q[w];
  end

  assign flags = flag_word(acc_q);
endmodule

// File: rtl/pnx_finder_chk.sv
module pnx_finder_chk
  import pnx_pkg::*;
#(
  parameter int NWORDS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     done,
  input logic                     evt_accept,
  input logic                     op_next,
  input logic [1:0]               esz,
  input logic [NWORDS*WORD_W-1:0] d_out,
  input logic [31:0]              flags
);
  logic [15:0]              lat_cnt;
  logic [NWORDS*WORD_W-1:0] full_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_cnt <= '0;
    else if (evt_accept) lat_cnt <= '0;
    else if (busy)       lat_cnt <= lat_cnt + 16'd1;
  end

  always_comb begin
    for (int w = 0; w < NWORDS; w++) full_mask[w*WORD_W +: WORD_W] = elem_mask(esz);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 16'(op_next ? 3*NWORDS : NWORDS))); // R10
  AST_NEXT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_next) |-> ($countones(d_out) <= 1)); // R3
  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_next) |-> ((d_out & ~full_mask) == '0)); // R2
  AST_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flags[2]) |-> (flags == 32'd1)); // R9
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R10
endmodule

bind pred_next_finder pnx_finder_chk #(.NWORDS(NWORDS)) u_pnx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .evt_accept (evt_accept),
  .op_next    (op_q),
  .esz        (esz_q),
  .d_out      (d_out),
  .flags      (flags)
);

// File: tb/pred_next_finder_tb.sv
module pred_next_finder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 4;
  localparam int TOT = NW * 64;

  typedef struct packed {
    logic           op;
    logic [1:0]     esz;
    logic [TOT-1:0] d;
    logic [TOT-1:0] g;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TV [NVEC] = '{
    '{1'b1, 2'd0, {64'h0, 64'h0, 64'h0, 64'h20}, {64'h0, 64'h0, 64'h0, 64'h248}},
    '{1'b1, 2'd1, {64'h0, 64'h0, 64'h0, 64'h10}, {64'h0, 64'h0, 64'h0, 64'h1A0}},
    '{1'b1, 2'd2, {64'h0, 64'h0, 64'h0, 64'h80}, {64'h0, 64'h0, 64'h0, 64'h1004}},
    '{1'b1, 2'd3, {64'h0, 64'h0, 64'h100, 64'h0}, {64'h0, 64'h1, 64'h100, 64'h0}},
    '{1'b1, 2'd0, {64'h8000000000000000, 64'h0, 64'h0, 64'h0}, {4{64'hFFFFFFFFFFFFFFFF}}},
    '{1'b1, 2'd0, {64'h0, 64'h0, 64'h0, 64'h0}, {64'h0, 64'h0, 64'h0, 64'h0}},
    '{1'b0, 2'd0, {64'h0, 64'h0, 64'h0, 64'hF0}, {64'h0, 64'h5, 64'h8, 64'h0}},
    '{1'b0, 2'd2, {64'h0, 64'h0, 64'h0, 64'h1234}, {64'h0, 64'h0, 64'h0, 64'h0}},
    '{1'b0, 2'd1, {64'h0, 64'h0, 64'h0, 64'h3}, {64'h0, 64'h0, 64'h0, 64'h2}},
    '{1'b1, 2'd0, {64'h0, 64'h8000000000000000, 64'h0, 64'h0}, {64'h1, 64'h0, 64'h0, 64'hF}},
    '{1'b1, 2'd1, {64'h0, 64'h0, 64'h400, 64'h0}, {64'h4000000000000000, 64'h0, 64'h1C00, 64'h0}},
    '{1'b1, 2'd3, {64'h0, 64'h0, 64'h0, 64'h1}, {64'h0, 64'h0, 64'h0, 64'h1FE}}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           op_next = 1'b0;
  logic [1:0]     esz = '0;
  logic [TOT-1:0] d_in = '0;
  logic [TOT-1:0] g_in = '0;
  logic           busy, done;
  logic [TOT-1:0] d_out;
  logic [31:0]    flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_next_finder #(.NWORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_next(op_next), .esz(esz),
    .d_in(d_in), .g_in(g_in), .busy(busy), .done(done), .d_out(d_out), .flags(flags)
  );

  // ---------------- reference model, bit by bit over the whole vector
  function automatic logic [31:0] ref_flags(input logic [TOT-1:0] d, input logic [TOT-1:0] g);
    int lo = -1;
    int hi = -1;
    if (g == '0) return 32'd1;
    for (int p = 0; p < TOT; p++) if (g[p]) begin
      if (lo < 0) lo = p;
      hi = p;
    end
    return {d[lo], 28'd0, 1'b1, |(d & g), ~d[hi]};
  endfunction

  function automatic logic [TOT-1:0] ref_qual(input logic [1:0] e);
    logic [TOT-1:0] m;
    for (int p = 0; p < TOT; p++) m[p] = ((p % (1 << e)) == 0);
    return m;
  endfunction

  function automatic logic [TOT-1:0] ref_result(input vec_t v);
    logic [TOT-1:0] r;
    logic [TOT-1:0] q;
    int last = -1;
    int from;
    if (!v.op) begin
      r = v.d;
      for (int p = 0; p < TOT; p++) if (v.g[p]) begin r[p] = 1'b1; break; end
      return r;
    end
    q = ref_qual(v.esz);
    for (int p = 0; p < TOT; p++) if (q[p] && v.d[p]) last = p;
    from = (last < 0) ? 0 : last + (1 << v.esz);
    r = '0;
    for (int p = from; p < TOT; p++) if (q[p] && v.g[p]) begin r[p] = 1'b1; break; end
    return r;
  endfunction

  function automatic logic [31:0] ref_cond(input vec_t v);
    logic [TOT-1:0] res;
    res = ref_result(v);
    return v.op ? ref_flags(res, v.g & ref_qual(v.esz)) : ref_flags(res, v.g);
  endfunction

  // ---------------- checking helpers
  task automatic chk_vec(input string req, input logic [TOT-1:0] got, input logic [TOT-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_int(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  logic [TOT-1:0] res_d;
  logic [31:0]    res_f;
  int             res_lat;

  task automatic wait_done();
    res_lat = 0;
    while (!done && res_lat < 200) begin
      @(negedge clk);
      res_lat++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10: watchdog, done never rose (got 0 expected 1)");
    end
    res_d = d_out;
    res_f = flags;
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    start = 1'b1; op_next = v.op; esz = v.esz; d_in = v.d; g_in = v.g;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL R10: global watchdog expired (got hang expected completion)");
    summary();
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_int("R1 busy", int'(busy), 0);
    chk_int("R1 done", int'(done), 0);
    chk_vec("R1 d_out", d_out, '0);
    chk_int("R1 flags", int'(flags), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      v = TV[i];
      issue(v);
      wait_done();
      chk_vec($sformatf("R3/R7 result vec %0d", i), res_d, ref_result(v));
      chk_int($sformatf("R6/R8 flags vec %0d", i), int'(res_f), int'(ref_cond(v)));
      chk_int($sformatf("R10 latency vec %0d", i), res_lat, v.op ? 3*NW : NW);
      @(negedge clk);
      chk_int($sformatf("R10 done pulse vec %0d", i), int'(done), 0);
    end

    // directed corner values, hand-derived
    v = TV[4];  issue(v); wait_done();
    chk_vec("R5 start past vector end", res_d, '0);
    chk_int("R6 flags empty result", int'(res_f), 5);
    v = TV[5];  issue(v); wait_done();
    chk_int("R9 empty governing flags", int'(res_f), 1);
    v = TV[2];  issue(v); wait_done();
    chk_vec("R4 R2 search from zero, word lanes", res_d, TOT'(1) << 12);
    v = TV[9];  issue(v); wait_done();
    chk_vec("R3 word boundary start", res_d, TOT'(1) << 192);
    v = TV[7];  issue(v); wait_done();
    chk_vec("R7 empty G keeps D", res_d, TOT'(64'h1234));

    // R11: second start while busy is ignored
    v = TV[0];
    issue(v);
    @(negedge clk);
    start = 1'b1; op_next = 1'b0; d_in = '1; g_in = '1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk_vec("R11 busy start ignored result", res_d, TOT'(1) << 6);
    chk_int("R11 busy start ignored latency", res_lat + 2, 3*NW);

    @(negedge clk);
    summary();
  end
endmodule